// File: doc/BRIEF.md
# Temperature Measurement Sequencer

This block decides when an on-chip temperature converter runs. It divides the functional clock down to a conversion clock and waits a programmable number of conversion-clock ticks so the analog front end can power up. It then runs conversions in one of three modes. Single mode takes one sample and stops. Continuous mode starts each conversion as soon as the previous one ends. Periodic mode starts a conversion at a fixed interval, counted in conversion-clock ticks.

The analog converter is modelled as a tick counter. Its length is set by the resolution input, and at the end it returns a test value. At the end of each conversion the block raises a one-cycle sample strobe and latches the 16-bit sample. It also sets a data-ready flag that stays set. Control comes from level inputs (enable, divider enable, mode, resolution, divider value, power-up delay, period) and from one-cycle start and stop pulses.

Top module: `temp_meas_seq`

## Requirements
- R1: After reset, `busy`, `drdy`, `sample_vld` and `conv_clk_en` are 0 and `sample` is 0.
- R2: While `enable` and `div_en` are both 1, `conv_clk_en` is high for one cycle in every `div`+1 cycles. While either of them is 0, `conv_clk_en` stays 0 and no conversion makes progress.
- R3: A start accepted from idle is followed by a power-up wait of `pud` conversion-clock ticks before the first conversion, and no wait when `pud` is 0. Later starts skip the wait until `enable` is cleared.
- R4: A conversion lasts LEN_R0, LEN_R1, LEN_R2 or LEN_R3 conversion-clock ticks for `res` = 0, 1, 2 or 3.
- R5: With `mode` 0, or with `mode` 3, the block completes one conversion and then returns to idle by itself.
- R6: With `mode` = 1, each conversion starts on the tick after the previous one ends, so strobes are spaced one conversion length apart.
- R7: With `mode` = 2, successive conversions start `period` ticks apart. If `period` is not larger than the conversion length, the next conversion starts straight after the current one ends.
- R8: One cycle after the final tick of a conversion, `sample_vld` pulses for one cycle and `sample` takes the value TEST_BASE + n, where n is the number of conversions completed since enable was set. `drdy` is set at the same time and stays set until `enable` is cleared or a new start is accepted from idle.
- R9: A stop pulse during a conversion takes effect when that conversion ends. During the power-up wait or the periodic gap it returns the block to idle on the next cycle. When start and stop arrive together, stop wins and the start is dropped.
- R10: Clearing `enable` aborts any activity and clears `busy` and `drdy` on the next cycle. The power-up wait is repeated after enable is set again.
- R11: `busy` is 1 from the cycle after an accepted start until the block returns to idle. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low aborts and idles |
| start | input | 1 | One-cycle start request |
| stop | input | 1 | One-cycle stop request |
| mode | input | 2 | 0 single, 1 continuous, 2 periodic, 3 single |
| res | input | 2 | Resolution, selects conversion length |
| div_en | input | 1 | Conversion clock divider enable |
| div | input | 8 | Divider value; conversion clock = clk/(div+1) |
| pud | input | 8 | Power-up wait in conversion-clock ticks |
| period | input | 24 | Periodic interval in conversion-clock ticks |
| conv_clk_en | output | 1 | Conversion clock tick |
| busy | output | 1 | Sequencer not idle |
| drdy | output | 1 | Data-ready flag |
| sample_vld | output | 1 | One-cycle strobe with a new sample |
| sample | output | 16 | Latest signed sample |

## Verification
Single mode is run with a divider of 2 and a nonzero power-up wait. It is then started again to show that the wait happens only once per enable. Continuous mode with an undivided clock shows back-to-back spacing and the sample count, and a stop issued early in a conversion lets exactly one more sample through. Periodic mode is run once with a period longer than the conversion and once with a shorter one, which shows whether the interval timer or the conversion length sets the spacing. Further runs cover start and stop in the same cycle, a start issued while busy, disabling in mid-conversion, and a gated-off divider, because each of these sits on a different branch of the control flow.

// File: rtl/temp_meas_seq.sv
module temp_meas_seq #(
  parameter int DIV_W  = 8,
  parameter int PUD_W  = 8,
  parameter int PER_W  = 24,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int LEN_R0 = 2373,
  parameter int LEN_R1 = 4421,
  parameter int LEN_R2 = 8517,
  parameter int LEN_R3 = 16709,
  parameter logic [DATA_W-1:0] TEST_BASE = 16'h0640
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              stop,
  input  logic [1:0]        mode,
  input  logic [1:0]        res,
  input  logic              div_en,
  input  logic [DIV_W-1:0]  div,
  input  logic [PUD_W-1:0]  pud,
  input  logic [PER_W-1:0]  period,
  output logic              conv_clk_en,
  output logic              busy,
  output logic              drdy,
  output logic              sample_vld,
  output logic [DATA_W-1:0] sample
);
  typedef enum logic [1:0] {S_IDLE, S_PWR, S_CONV, S_GAP} st_t;

  st_t               st;
  logic [DIV_W-1:0]  dcnt;
  logic [CNT_W-1:0]  cnt;
  logic [PER_W-1:0]  pcnt;
  logic [DATA_W-1:0] seq;
  logic              pwr_ok, stop_pend;
  logic [CNT_W-1:0]  len;
  logic              tick, last_tick, go, is_cont, is_per;

  always_comb begin
    case (res)
      2'd0:    len = CNT_W'(LEN_R0);
      2'd1:    len = CNT_W'(LEN_R1);
      2'd2:    len = CNT_W'(LEN_R2);
      default: len = CNT_W'(LEN_R3);
    endcase
  end

  assign tick        = enable & div_en & (dcnt == div);
  assign last_tick   = tick & (cnt == len - 1'b1);
  assign go          = start & ~stop;
  assign is_cont     = (mode == 2'd1);
  assign is_per      = (mode == 2'd2);
  assign conv_clk_en = tick;
  assign busy        = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         dcnt <= '0;
    else if (!enable || !div_en || tick) dcnt <= '0;
    else                                dcnt <= dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; pcnt <= '0; seq <= '0;
      pwr_ok <= 1'b0; stop_pend <= 1'b0;
      drdy <= 1'b0; sample_vld <= 1'b0; sample <= '0;
    end else if (!enable) begin
      st <= S_IDLE; cnt <= '0; pcnt <= '0; seq <= '0;
      pwr_ok <= 1'b0; stop_pend <= 1'b0;
      drdy <= 1'b0; sample_vld <= 1'b0;
    end else begin
      sample_vld <= (st == S_CONV) & last_tick;
      case (st)
        S_IDLE: if (go) begin
          drdy <= 1'b0; cnt <= '0; pcnt <= '0; stop_pend <= 1'b0;
          if (!pwr_ok && pud != '0) st <= S_PWR;
          else begin st <= S_CONV; pwr_ok <= 1'b1; end
        end
        S_PWR: begin
          if (stop) st <= S_IDLE;
          else if (tick) begin
            if (32'(cnt) + 1 == 32'(pud)) begin
              st <= S_CONV; cnt <= '0; pwr_ok <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
        end
        S_CONV: begin
          if (stop) stop_pend <= 1'b1;
          if (tick) begin
            pcnt <= pcnt + 1'b1;
            if (last_tick) begin
              sample <= TEST_BASE + seq;
              seq    <= seq + 1'b1;
              drdy   <= 1'b1;
              cnt    <= '0;
              if (stop || stop_pend || !(is_cont || is_per)) st <= S_IDLE;
              else if (is_cont || 32'(len) >= 32'(period)) pcnt <= '0;
              else st <= S_GAP;
            end else cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (stop) st <= S_IDLE;
          else if (tick) begin
            if (32'(pcnt) + 1 >= 32'(period)) begin
              st <= S_CONV; pcnt <= '0;
            end else pcnt <= pcnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R10
  disable_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !drdy));

  // R8
  vld_sets_drdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> drdy);

  // R4
  vld_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |-> $past(conv_clk_en));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && enable && start && !stop) |=> busy);

  // R9
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && stop) |=> !busy);

  // R5
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld && $past(mode) != 2'd1 && $past(mode) != 2'd2) |-> !busy);
endmodule

// File: tb/temp_meas_seq_tb_top.sv
module temp_meas_seq_tb_top;
  localparam int L0 = 12, L1 = 17, L2 = 23, L3 = 31;
  localparam logic [15:0] BASE = 16'h0100;

  logic clk = 0, rst_n = 0, enable = 0, start = 0, stop = 0, div_en = 0;
  logic [1:0] mode = 0, res = 0;
  logic [7:0] div = 0, pud = 0;
  logic [23:0] period = 0;
  logic conv_clk_en, busy, drdy, sample_vld;
  logic [15:0] sample;

  int checks = 0, errors = 0;
  int cyc = 0, last_vld = 0, vld_gap = 0, nvld = 0, nticks = 0;

  temp_meas_seq #(.LEN_R0(L0), .LEN_R1(L1), .LEN_R2(L2), .LEN_R3(L3),
                  .TEST_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .stop(stop),
    .mode(mode), .res(res), .div_en(div_en), .div(div), .pud(pud),
    .period(period), .conv_clk_en(conv_clk_en), .busy(busy), .drdy(drdy),
    .sample_vld(sample_vld), .sample(sample));

  always #5 clk = ~clk;

  // behavioural reference
  int ms = 0, md = 0, mc = 0, mp = 0, mseq = 0, msamp = 0;
  bit mok = 0, mstp = 0, mdrdy = 0, mvld = 0;

  function automatic int lenof(input int r);
    return r == 0 ? L0 : r == 1 ? L1 : r == 2 ? L2 : L3;
  endfunction

  always @(posedge clk) begin
    bit tk;
    int ln;
    tk = enable && div_en && md == int'(div);
    ln = lenof(int'(res));
    if (!rst_n) begin
      ms = 0; md = 0; mc = 0; mp = 0; mseq = 0; msamp = 0;
      mok = 0; mstp = 0; mdrdy = 0; mvld = 0;
    end else begin
      md = (!enable || !div_en || tk) ? 0 : md + 1;
      if (!enable) begin
        ms = 0; mc = 0; mp = 0; mseq = 0; mok = 0; mstp = 0; mdrdy = 0; mvld = 0;
      end else begin
        mvld = (ms == 2) && tk && (mc == ln - 1);
        if (ms == 0) begin
          if (start && !stop) begin
            mdrdy = 0; mc = 0; mp = 0; mstp = 0;
            if (!mok && pud != 0) ms = 1; else begin ms = 2; mok = 1; end
          end
        end else if (ms == 1) begin
          if (stop) ms = 0;
          else if (tk) begin
            mc++;
            if (mc == int'(pud)) begin ms = 2; mc = 0; mok = 1; end
          end
        end else if (ms == 2) begin
          if (stop) mstp = 1;
          if (tk) begin
            mp++;
            mc++;
            if (mc == ln) begin
              msamp = (int'(BASE) + mseq) & 16'hffff; mseq++; mdrdy = 1; mc = 0;
              if (mstp || (mode != 1 && mode != 2)) ms = 0;
              else if (mode == 1 || ln >= int'(period)) mp = 0;
              else ms = 3;
            end
          end
        end else begin
          if (stop) ms = 0;
          else if (tk) begin
            mp++;
            if (mp >= int'(period)) begin ms = 2; mp = 0; end
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison with the reference, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R2 conv_clk_en", int'(conv_clk_en), int'(enable && div_en && md == int'(div)));
      chk("R11 busy", int'(busy), int'(ms != 0));
      chk("R8 drdy", int'(drdy), int'(mdrdy));
      chk("R8 sample_vld", int'(sample_vld), int'(mvld));
      chk("R8 sample", int'(sample), msamp);
    end
    if (conv_clk_en) nticks++;
    if (sample_vld) begin
      nvld++; vld_gap = cyc - last_vld; last_vld = cyc;
    end
  end

  task automatic tk_wait(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start = 1;
    @(negedge clk); #1 start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); #1 stop = 1;
    @(negedge clk); #1 stop = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    #1;
  endtask

  task automatic wait_vlds(input int n);
    int target;
    target = nvld + n;
    for (int i = 0; i < 5000 && nvld < target; i++) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n0;
    tk_wait(3);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 drdy", int'(drdy), 0);
    chk("R1 sample_vld", int'(sample_vld), 0);
    chk("R1 conv_clk_en", int'(conv_clk_en), 0);
    chk("R1 sample", int'(sample), 0);
    @(negedge clk); #1 rst_n = 1;

    // R2 R3 R4 R5: single mode, divided clock, power-up wait
    enable = 1; div_en = 1; div = 2; pud = 3; res = 0; mode = 0;
    tk_wait(2);
    n0 = nticks; tk_wait(30);
    chk("R2 tick count over 30 cycles", nticks - n0, 10);
    n0 = nvld;
    pulse_start();
    chk("R11 busy after start", int'(busy), 1);
    wait_idle();
    chk("R5 one sample in single mode", nvld - n0, 1);
    chk("R8 first sample", int'(sample), int'(BASE));
    chk("R8 drdy held", int'(drdy), 1);
    pulse_start();           // R3: no power-up wait this time
    chk("R8 drdy cleared by new start", int'(drdy), 0);
    wait_idle();
    chk("R8 second sample", int'(sample), int'(BASE) + 1);

    // R6 R9: continuous, undivided clock, stop early in a conversion
    div = 0; res = 1; mode = 1;
    pulse_start();
    wait_vlds(3);
    chk("R6 continuous spacing", vld_gap, L1);
    n0 = nvld;
    pulse_stop();
    chk("R9 still busy after stop", int'(busy), 1);
    wait_idle();
    chk("R9 one more sample after stop", nvld - n0, 1);

    // R7: periodic, period longer than conversion
    res = 2; mode = 2; period = 60;
    pulse_start();
    wait_vlds(3);
    chk("R7 periodic spacing", vld_gap, 60);
    tk_wait(5);              // inside the gap
    pulse_stop();            // R9: immediate in gap
    chk("R9 idle after stop in gap", int'(busy), 0);

    // R10: disable mid conversion, power-up repeated
    pulse_start();
    tk_wait(6);
    @(negedge clk); #1 enable = 0;
    tk_wait(1);
    chk("R10 busy cleared", int'(busy), 0);
    chk("R10 drdy cleared", int'(drdy), 0);
    period = 10; enable = 1;
    pulse_start();
    wait_vlds(3);
    chk("R7 short period back to back", vld_gap, L2);
    pulse_stop();
    wait_idle();

    // R9: start and stop together
    @(negedge clk); #1 start = 1; stop = 1;
    @(negedge clk); #1 start = 0; stop = 0;
    chk("R9 stop wins over start", int'(busy), 0);

    // R11 R4: start while busy ignored, longest resolution
    res = 3; mode = 3;
    n0 = nvld;
    pulse_start();
    tk_wait(8);
    pulse_start();
    wait_idle();
    chk("R11 start while busy ignored", nvld - n0, 1);
    chk("R5 mode 3 acts single", int'(busy), 0);

    // R2: divider gated off, no progress
    div_en = 0;
    n0 = nticks;
    pulse_start();
    tk_wait(100);
    chk("R2 no ticks with divider off", nticks - n0, 0);
    chk("R2 stuck busy without ticks", int'(busy), 1);
    @(negedge clk); #1 enable = 0;
    tk_wait(2);
    chk("R10 idle after disable", int'(busy), 0);

    finish_run();
  end
endmodule